// File: doc/BRIEF.md
# PFC Enable Controller with Switch-Off Delay

This block decides, cycle by cycle, whether the power-factor-correction stage of a two-stage supply may switch. It measures the flyback switching period by counting reference clocks between rising edges of the flyback gate signal and sorts each period into one of three bands: fast, middle and slow. A fast period turns the stage on at once. A slow period starts a digital switch-off delay that stands in for an external timing capacitor. A middle period keeps the present decision, which gives the hysteresis.

The delay counter is discharged on every fast period and also whenever a flag reports that the flyback maximum-frequency setting lies above its own threshold. This stops the stage from toggling on and off while the load moves the flyback back and forth across the thresholds. Two override flags model an external control pin that is held low (stage forced on) or held high (stage forced off). The overrides take priority over the frequency-based decision but do not disturb it.

Top module: `pfc_gate_ctrl`

## Requirements
- R1: During reset and after its release, before any decision is made, pfc_en_o and tmr_clr_o are 0.
- R2: The measured period is the number of clk cycles between two consecutive rising edges of fb_gate_i, sampled on clk. The first rising edge after reset only starts the measurement and is not classified.
- R3: A period shorter than HI_BELOW = CLK_HZ/F_ON_HZ (integer division) is fast. With no override active, pfc_en_o and tmr_clr_o are 1 in the second clock after the edge that closes the period.
- R4: A period longer than LO_ABOVE = CLK_HZ/F_OFF_HZ is slow, and so is the absence of any edge for LO_ABOVE+1 cycles. If the gate stops after a fast edge at clock E, pfc_en_o is still 1 after clock E+LO_ABOVE+HOLD_CYC and is 0 after clock E+LO_ABOVE+HOLD_CYC+1.
- R5: A period from HI_BELOW to LO_ABOVE inclusive is middle. It neither turns an off stage on nor turns an on stage off, and it freezes the delay counter.
- R6: While fmax_hi_i is 1, the delay counter is held at zero, tmr_clr_o is 1 from the next clock on, and the stage does not switch off. When fmax_hi_i is released in the slow band, pfc_en_o falls HOLD_CYC clocks later.
- R7: A fast period that arrives while the delay is counting restarts the full delay. The stage stays on past the point where the first countdown would have ended.
- R8: force_on_i = 1 makes pfc_en_o 1 from the next clock on. This holds even when force_off_i is also 1.
- R9: force_off_i = 1 with force_on_i = 0 makes pfc_en_o 0 from the next clock on.
- R10: The overrides do not change the frequency-based state. Once both are released, pfc_en_o follows that state from the next clock on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that counts the flyback period |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_gate_i | input | 1 | Flyback gate drive, synchronous to clk |
| fmax_hi_i | input | 1 | Flyback maximum-frequency setting lies above its threshold |
| force_on_i | input | 1 | Control pin held low: stage forced on |
| force_off_i | input | 1 | Control pin held high: stage forced off |
| pfc_en_o | output | 1 | PFC stage enable |
| tmr_clr_o | output | 1 | Delay counter being discharged this cycle |

## Verification
The bench builds the block with CLK_HZ = 730000 and HOLD_CYC = 20. These values make HI_BELOW exactly 10 and LO_ABOVE 13 clocks. With periods of only a few clocks, both boundaries can be probed directly: 9 and 10 on the fast side, 13 and 14 on the slow side. The short delay lets the bench check the exact switch-off clock, the restart of the delay by a late fast pair, and the hold under fmax_hi_i, all within a few hundred cycles.

// File: rtl/pfc_gate_pkg.sv
// Shared types for the PFC enable controller.
package pfc_gate_pkg;

    // Frequency band of the most recent flyback period.
    typedef enum logic [1:0] {
        BAND_LOW  = 2'd0,
        BAND_MID  = 2'd1,
        BAND_HIGH = 2'd2
    } fband_e;

endpackage

// File: rtl/pfc_period_meter.sv
// Counts reference clocks between rising edges of the flyback gate.
// Assumes fb_gate_i is already synchronous to clk. The counter saturates at
// SAT_VAL. stale_o reports that no edge arrived within SAT_VAL-1 cycles.
// The first edge after reset only arms the meter.
module pfc_period_meter #(
    parameter int CNT_W   = 10,
    parameter int SAT_VAL = 944
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    output logic             meas_vld_o,
    output logic [CNT_W-1:0] meas_per_o,
    output logic             stale_o
);

    logic             gate_q;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             rise;

    assign rise    = gate_i & ~gate_q;
    assign stale_o = (cnt == CNT_W'(SAT_VAL));

    // Delay the gate by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_i;
    end

    // Count the clocks since the last edge, saturating at SAT_VAL.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (rise)                   cnt <= CNT_W'(1);
        else if (cnt != CNT_W'(SAT_VAL)) cnt <= cnt + CNT_W'(1);
    end

    // Arm on the first edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    armed <= 1'b0;
        else if (rise) armed <= 1'b1;
    end

    // Publish a period on every armed edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_vld_o <= 1'b0;
            meas_per_o <= '0;
        end else begin
            meas_vld_o <= rise & armed;
            if (rise & armed) meas_per_o <= cnt;
        end
    end

    // Edges need a low cycle between them, so no period is shorter than 2.
    assert_min_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld_o |-> (meas_per_o >= CNT_W'(2)));

endmodule

// File: rtl/pfc_band_sorter.sv
// Sorts each measured period into a frequency band and holds it.
// A stale meter (no edge for too long) forces the slow band.
module pfc_band_sorter
    import pfc_gate_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int HI_BELOW = 684,
    parameter int LO_ABOVE = 943
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_vld_i,
    input  logic [CNT_W-1:0] meas_per_i,
    input  logic             stale_i,
    output fband_e           band_o
);

    fband_e band_n;

    // Map a fresh period, or staleness, to the next band.
    always_comb begin
        band_n = band_o;
        if (meas_vld_i) begin
            if (meas_per_i < CNT_W'(HI_BELOW))      band_n = BAND_HIGH;
            else if (meas_per_i > CNT_W'(LO_ABOVE)) band_n = BAND_LOW;
            else                                    band_n = BAND_MID;
        end else if (stale_i) begin
            band_n = BAND_LOW;
        end
    end

    // Hold the band between measurements.
    always_ff @(posedge clk) begin
        if (!rst_n) band_o <= BAND_LOW;
        else        band_o <= band_n;
    end

    assert_stale_slow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stale_i && !meas_vld_i) |=> (band_o == BAND_LOW));

    assert_fast_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld_i && (meas_per_i < CNT_W'(HI_BELOW))) |=> (band_o == BAND_HIGH));

    assert_mid_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld_i && (meas_per_i >= CNT_W'(HI_BELOW)) && (meas_per_i <= CNT_W'(LO_ABOVE)))
        |=> (band_o == BAND_MID));

endmodule

// File: rtl/pfc_offdelay_timer.sv
// Switch-off delay counter. It is cleared by clr_i and advances while run_i
// is set. expire_o marks the cycle in which the last count is taken.
// Assumes the caller never sets clr_i and run_i together.
module pfc_offdelay_timer #(
    parameter int HOLD_CYC = 4_000_000,
    parameter int TMR_W    = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expire_o
);

    logic [TMR_W-1:0] tmr;

    assign expire_o = run_i && (tmr == TMR_W'(HOLD_CYC - 1));

    // Discharge, advance, or wrap to zero on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)         tmr <= '0;
        else if (clr_i)     tmr <= '0;
        else if (expire_o)  tmr <= '0;
        else if (run_i)     tmr <= tmr + TMR_W'(1);
    end

    assert_tmr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr < TMR_W'(HOLD_CYC));

    assert_tmr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (tmr == '0));

    assert_tmr_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !run_i) |=> $stable(tmr));

endmodule

// File: rtl/pfc_gate_ctrl.sv
// PFC enable controller. Measures the flyback period and applies two-band
// hysteresis with a switch-off delay. The delay is cleared by a fast flyback
// or by a high maximum-frequency setting. Two override flags take priority.
// Assumes all inputs are synchronous to clk and F_ON_HZ > F_OFF_HZ.
module pfc_gate_ctrl
    import pfc_gate_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int F_ON_HZ  = 73_000,
    parameter int F_OFF_HZ = 53_000,
    parameter int HOLD_CYC = 4_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_gate_i,
    input  logic fmax_hi_i,
    input  logic force_on_i,
    input  logic force_off_i,
    output logic pfc_en_o,
    output logic tmr_clr_o
);

    localparam int HI_BELOW = CLK_HZ / F_ON_HZ;
    localparam int LO_ABOVE = CLK_HZ / F_OFF_HZ;
    localparam int SAT_VAL  = LO_ABOVE + 1;
    localparam int CNT_W    = $clog2(SAT_VAL + 1);
    localparam int TMR_W    = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;

    logic             meas_vld;
    logic [CNT_W-1:0] meas_per;
    logic             stale;
    fband_e           band;
    logic             freq_on;
    logic             freq_on_n;
    logic             clr;
    logic             run;
    logic             expire;

    pfc_period_meter #(
        .CNT_W   (CNT_W),
        .SAT_VAL (SAT_VAL)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_i     (fb_gate_i),
        .meas_vld_o (meas_vld),
        .meas_per_o (meas_per),
        .stale_o    (stale)
    );

    pfc_band_sorter #(
        .CNT_W    (CNT_W),
        .HI_BELOW (HI_BELOW),
        .LO_ABOVE (LO_ABOVE)
    ) u_sorter (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_vld_i (meas_vld),
        .meas_per_i (meas_per),
        .stale_i    (stale),
        .band_o     (band)
    );

    // Discharge on a fast flyback or a high max-frequency setting; count only
    // in the slow band while the stage is on.
    assign clr = (band == BAND_HIGH) || fmax_hi_i;
    assign run = (band == BAND_LOW) && freq_on && !fmax_hi_i;

    pfc_offdelay_timer #(
        .HOLD_CYC (HOLD_CYC),
        .TMR_W    (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .run_i    (run),
        .expire_o (expire)
    );

    // Next frequency-based decision: a fast band sets it, expiry drops it.
    always_comb begin
        freq_on_n = freq_on;
        if (band == BAND_HIGH) freq_on_n = 1'b1;
        else if (expire)       freq_on_n = 1'b0;
    end

    // Register the decision, the overridden enable and the discharge flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_on   <= 1'b0;
            pfc_en_o  <= 1'b0;
            tmr_clr_o <= 1'b0;
        end else begin
            freq_on   <= freq_on_n;
            tmr_clr_o <= clr;
            if (force_on_i)       pfc_en_o <= 1'b1;
            else if (force_off_i) pfc_en_o <= 1'b0;
            else                  pfc_en_o <= freq_on_n;
        end
    end

    assert_force_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_on_i |=> pfc_en_o);

    assert_force_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (force_off_i && !force_on_i) |=> !pfc_en_o);

    assert_hold_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fmax_hi_i |=> tmr_clr_o);

    assert_fast_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((band == BAND_HIGH) && !force_on_i && !force_off_i) |=> pfc_en_o);

    assert_no_drop_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fmax_hi_i && freq_on) |=> freq_on);

endmodule

// File: tb/pfc_gate_ctrl_test.sv
`timescale 1ns/1ps
module pfc_gate_ctrl_test;

    localparam int CLK_HZ   = 730_000;
    localparam int HOLD     = 20;
    localparam int LO_ABOVE = 13;
    localparam int NVEC     = 9;

    // Table: period in clocks, number of edges, expected enable afterwards.
    localparam int VP [NVEC] = '{20, 12, 10, 9, 13, 11, 14, 12, 5};
    localparam int VN [NVEC] = '{ 4,  4,  4, 3,  4,  3,  4,  3, 3};
    localparam int VE [NVEC] = '{ 0,  0,  0, 1,  1,  1,  0,  0, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_gate = 1'b0;
    logic fmax_hi = 1'b0;
    logic force_on = 1'b0;
    logic force_off = 1'b0;
    logic pfc_en;
    logic tmr_clr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pfc_gate_ctrl #(
        .CLK_HZ   (CLK_HZ),
        .F_ON_HZ  (73_000),
        .F_OFF_HZ (53_000),
        .HOLD_CYC (HOLD)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fb_gate_i   (fb_gate),
        .fmax_hi_i   (fmax_hi),
        .force_on_i  (force_on),
        .force_off_i (force_off),
        .pfc_en_o    (pfc_en),
        .tmr_clr_o   (tmr_clr)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // One rising edge; returns at the negedge just after the edge's clock.
    task automatic fire_edge();
        @(negedge clk) fb_gate = 1'b1;
        @(negedge clk) fb_gate = 1'b0;
    endtask

    task automatic train(input int p, input int n);
        for (int k = 0; k < n; k++) begin
            fire_edge();
            idle(p - 2);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fb_gate = 1'b0; fmax_hi = 1'b0;
        force_on = 1'b0; force_off = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    // Enable the stage with a fast pair; returns at negedge of second edge.
    task automatic fast_pair();
        fire_edge();
        idle(7);
        fire_edge();
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 enable after reset", pfc_en, 1'b0);
        chk("R1 clear flag after reset", tmr_clr, 1'b0);
        idle(30);
        chk("R1 enable idle after reset", pfc_en, 1'b0);

        // Table walk: R2 R3 R4 R5 across band boundaries
        for (int i = 0; i < NVEC; i++) begin
            train(VP[i], VN[i]);
            chk($sformatf("R5 R3 R4 table entry %0d period %0d", i, VP[i]), pfc_en, VE[i][0]);
        end

        // R2 R3: exact turn-on latency; first edge only arms
        do_reset();
        fire_edge();
        idle(2);
        chk("R2 first edge only arms", pfc_en, 1'b0);
        idle(4);
        fire_edge();
        idle(1);
        chk("R3 not yet on one clock after edge", pfc_en, 1'b0);
        idle(1);
        chk("R3 on two clocks after edge", pfc_en, 1'b1);
        chk("R3 discharge flag on fast band", tmr_clr, 1'b1);

        // R4: exact switch-off clock with gate stopped (now at E+2)
        idle(LO_ABOVE + HOLD - 2);
        chk("R4 still on at last delay clock", pfc_en, 1'b1);
        chk("R4 discharge flag low in slow band", tmr_clr, 1'b0);
        idle(1);
        chk("R4 off after delay", pfc_en, 1'b0);

        // R7: fast pair during countdown restarts delay
        fast_pair();              // edge E
        idle(2);
        chk("R7 on before countdown", pfc_en, 1'b1);
        idle(17);
        fast_pair();              // edges E+21 and E+30
        idle(5);
        chk("R7 on past first countdown end", pfc_en, 1'b1);
        idle(28);
        chk("R7 on at last clock of restarted delay", pfc_en, 1'b1);
        idle(1);
        chk("R7 off after restarted delay", pfc_en, 1'b0);

        // R6: max-frequency flag holds the stage on
        fast_pair();
        idle(2);
        fmax_hi = 1'b1;
        idle(60);
        chk("R6 held on while flag set", pfc_en, 1'b1);
        chk("R6 discharge flag while held", tmr_clr, 1'b1);
        fmax_hi = 1'b0;
        idle(HOLD - 1);
        chk("R6 on until delay after release", pfc_en, 1'b1);
        idle(1);
        chk("R6 off after release delay", pfc_en, 1'b0);
        chk("R6 discharge flag released", tmr_clr, 1'b0);

        // R8 R9 R10: overrides with the frequency state off
        force_on = 1'b1;
        idle(1);
        chk("R8 forced on", pfc_en, 1'b1);
        force_off = 1'b1;
        idle(1);
        chk("R8 force-on wins over force-off", pfc_en, 1'b1);
        force_on = 1'b0;
        idle(1);
        chk("R9 forced off", pfc_en, 1'b0);
        force_off = 1'b0;
        idle(1);
        chk("R10 release returns to off state", pfc_en, 1'b0);

        // R9 R10: overrides with the frequency state on
        fast_pair();
        fmax_hi = 1'b1;
        idle(2);
        chk("R10 on before force-off", pfc_en, 1'b1);
        force_off = 1'b1;
        idle(1);
        chk("R9 forced off over on state", pfc_en, 1'b0);
        idle(40);
        chk("R9 stays off while forced", pfc_en, 1'b0);
        force_off = 1'b0;
        idle(1);
        chk("R10 release returns to on state", pfc_en, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule